// File: doc/BRIEF.md
# Joinable Dual-Direction Word FIFO Pair

This block moves 32-bit words between a host bus and a single sequencer. Host writes go into a transmit queue that the sequencer pulls from. Sequencer pushes go into a receive queue that the host pops from. Both queues live in one shared eight-word storage array.

By default the array is divided evenly, with four words for each direction. A two-bit join control can give the whole array to one direction. The other direction then has zero capacity. Any change of the join setting empties both queues.

Each queue is a wrapping ring with its own read and write pointers and a separate occupancy counter, so a full ring and an empty ring can be told apart. The block reports per-direction levels, full and empty flags, and four sticky error bits for overrun and underrun. The host clears each error bit by writing a 1 to it.

Top module: `fifo_pair`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, all four error bits are 0, the partition is the even split, and both read-data outputs are 0.
- R2: With join_mode 0 (or 3), each direction holds 4 words. The full flag of a direction rises when its level reaches 4.
- R3: Words leave each queue in the order they entered, including after the pointers wrap. Each read-data output shows the head word of its queue before it is popped, and shows 0 while that queue is empty.
- R4: A push into a full queue is discarded and sets that queue's overrun bit. The level stays unchanged. err_flags bit 0 is transmit overrun and bit 2 is receive overrun.
- R5: A pop from an empty queue leaves the level at 0 and sets that queue's underrun bit. err_flags bit 1 is transmit underrun and bit 3 is receive underrun.
- R6: Error bits stay set until a 1 is written to the matching bit of err_clear. If an error event and a clear of the same bit happen in the same cycle, the bit stays set.
- R7: With join_mode 1, the transmit queue holds 8 words. The receive queue has zero capacity, reports both full and empty, and a sequencer push to it sets receive overrun.
- R8: With join_mode 2, the receive queue holds 8 words. The transmit queue has zero capacity, reports both full and empty, and a host push to it sets transmit overrun.
- R9: On the first clock edge where join_mode selects a different partition, both levels become 0. Any push or pop in that cycle is ignored, and the error bits keep their values.
- R10: A push and a pop on the same queue in the same cycle, when it is neither full nor empty, both take effect. The level stays the same and the head advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| join_mode | input | 2 | 0/3 split, 1 all to transmit, 2 all to receive |
| host_push | input | 1 | Host writes a word into the transmit queue |
| host_wdata | input | 32 | Word written by the host |
| host_pop | input | 1 | Host removes the head word of the receive queue |
| host_rdata | output | 32 | Head word of the receive queue, 0 when empty |
| seq_pull | input | 1 | Sequencer removes the head word of the transmit queue |
| seq_pull_data | output | 32 | Head word of the transmit queue, 0 when empty |
| seq_push | input | 1 | Sequencer writes a word into the receive queue |
| seq_push_data | input | 32 | Word written by the sequencer |
| tx_level | output | 4 | Words held in the transmit queue |
| rx_level | output | 4 | Words held in the receive queue |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue holds no word |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue holds no word |
| err_flags | output | 4 | Sticky errors: tx overrun, tx underrun, rx overrun, rx underrun (bits 0..3) |
| err_clear | input | 4 | Write-one-to-clear strobes for err_flags |

## Verification
The hardest case to reach is a wrapped ring: the read pointer must sit past the middle of a region while the write pointer has already crossed the region boundary. Otherwise the ordering check says nothing about the pointer wrap. The stimulus gets there by partly filling the receive queue, popping two words, and then refilling it to capacity before draining it. A second hard case is a partition change that arrives in the same cycle as a push while the other queue still holds data. The bench leaves receive words pending, then asserts the new join setting and a host push together, and checks that both levels read zero afterwards.

// File: rtl/fifo_pair_pkg.sv
// Shared types for the joinable FIFO pair.
// Assumes: join_mode encoding 0/3 = split, 1 = transmit owns all, 2 = receive owns all.
package fifo_pair_pkg;
    typedef enum logic [1:0] {
        PART_SPLIT = 2'd0,
        PART_TX    = 2'd1,
        PART_RX    = 2'd2
    } part_e;
endpackage

// File: rtl/fifo_pair_store.sv
// Shared word storage with one write port and one read port per direction.
// Assumes the two write ports never address the same slot in one cycle
// (the controllers own disjoint regions).
module fifo_pair_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] mem [DEPTH];

    // Write accepted words into their slots.
    always_ff @(posedge clk) begin
        if (wa_en) mem[wa_addr] <= wa_data;
        if (wb_en) mem[wb_addr] <= wb_data;
    end

    // Present the addressed words combinationally.
    always_comb begin
        ra_data = mem[ra_addr];
        rb_data = mem[rb_addr];
    end
endmodule

// File: rtl/fifo_pair_ctrl.sv
// Ring controller for one direction: pointers, occupancy and sticky errors.
// Assumes base + cap <= DEPTH, and that cap changes only together with flush.
// With cap = 0 the queue reports both full and empty.
module fifo_pair_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [LW-1:0] cap,
    input  logic [AW-1:0] base,
    input  logic          push,
    input  logic          pop,
    input  logic          clr_over,
    input  logic          clr_under,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          over,
    output logic          under
);
    logic [AW-1:0] wptr_q, rptr_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop, over_set, under_set;

    // Decode status and which requests are accepted this cycle.
    always_comb begin
        full      = (cnt_q == cap);
        empty     = (cnt_q == '0);
        do_push   = push & ~full & ~flush;
        do_pop    = pop & ~empty & ~flush;
        over_set  = push & full & ~flush;
        under_set = pop & empty & ~flush;
        wr_en     = do_push;
        wr_addr   = base + wptr_q;
        rd_addr   = base + rptr_q;
        level     = cnt_q;
    end

    // Advance the pointers and the occupancy, or clear them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wptr_q <= (LW'(wptr_q) == cap - 1'b1) ? '0 : wptr_q + 1'b1;
            if (do_pop)
                rptr_q <= (LW'(rptr_q) == cap - 1'b1) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
        end
    end

    // Hold the error bits; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over  <= 1'b0;
            under <= 1'b0;
        end else begin
            if (over_set)       over <= 1'b1;
            else if (clr_over)  over <= 1'b0;
            if (under_set)      under <= 1'b1;
            else if (clr_under) under <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_pair.sv
// Top of the joinable FIFO pair: partition register, region decode, two ring
// controllers over one shared store. Host feeds transmit and drains receive;
// the sequencer drains transmit and feeds receive. Empty queues read as 0.
module fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    join_mode,
    input  logic          host_push,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_pop,
    output logic [DW-1:0] host_rdata,
    input  logic          seq_pull,
    output logic [DW-1:0] seq_pull_data,
    input  logic          seq_push,
    input  logic [DW-1:0] seq_push_data,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_empty,
    output logic [3:0]    err_flags,
    input  logic [3:0]    err_clear
);
    part_e         part_q, part_req;
    logic          flush;
    logic [LW-1:0] tx_cap, rx_cap;
    logic [AW-1:0] rx_base;
    logic          tx_wen, rx_wen;
    logic [AW-1:0] tx_waddr, tx_raddr, rx_waddr, rx_raddr;
    logic [DW-1:0] tx_head, rx_head;

    // Map the requested join setting and size both regions from the current one.
    always_comb begin
        unique case (join_mode)
            2'd1:    part_req = PART_TX;
            2'd2:    part_req = PART_RX;
            default: part_req = PART_SPLIT;
        endcase
        flush = (part_req != part_q);
        unique case (part_q)
            PART_TX: begin tx_cap = LW'(DEPTH); rx_cap = '0;          rx_base = AW'(HALF); end
            PART_RX: begin tx_cap = '0;          rx_cap = LW'(DEPTH); rx_base = '0;        end
            default: begin tx_cap = LW'(HALF);  rx_cap = LW'(HALF);  rx_base = AW'(HALF); end
        endcase
    end

    // Track the active partition.
    always_ff @(posedge clk) begin
        if (!rst_n) part_q <= PART_SPLIT;
        else        part_q <= part_req;
    end

    fifo_pair_ctrl #(.DEPTH(DEPTH)) tx_ctrl_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(tx_cap), .base('0),
        .push(host_push), .pop(seq_pull),
        .clr_over(err_clear[0]), .clr_under(err_clear[1]),
        .wr_en(tx_wen), .wr_addr(tx_waddr), .rd_addr(tx_raddr),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .over(err_flags[0]), .under(err_flags[1])
    );

    fifo_pair_ctrl #(.DEPTH(DEPTH)) rx_ctrl_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(rx_cap), .base(rx_base),
        .push(seq_push), .pop(host_pop),
        .clr_over(err_clear[2]), .clr_under(err_clear[3]),
        .wr_en(rx_wen), .wr_addr(rx_waddr), .rd_addr(rx_raddr),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .over(err_flags[2]), .under(err_flags[3])
    );

    fifo_pair_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
        .clk(clk),
        .wa_en(tx_wen), .wa_addr(tx_waddr), .wa_data(host_wdata),
        .wb_en(rx_wen), .wb_addr(rx_waddr), .wb_data(seq_push_data),
        .ra_addr(tx_raddr), .ra_data(tx_head),
        .rb_addr(rx_raddr), .rb_data(rx_head)
    );

    // Empty queues read as zero.
    always_comb begin
        seq_pull_data = tx_empty ? '0 : tx_head;
        host_rdata    = rx_empty ? '0 : rx_head;
    end
endmodule

// File: rtl/fifo_pair_chk.sv
// Checker for fifo_pair: level bounds, level movement, error stickiness,
// capacity of the disabled direction. Attached by the bind below.
module fifo_pair_chk #(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic [1:0]    part_q,
    input logic          host_push,
    input logic          seq_pull,
    input logic          seq_push,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_full,
    input logic          tx_empty,
    input logic [3:0]    err_flags,
    input logic [3:0]    err_clear
);
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    assert_tx_rise_needs_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level > $past(tx_level)) |-> $past(host_push));

    assert_tx_fall_needs_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level < $past(tx_level)) |-> ($past(seq_pull) || $past(flush)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && host_push && !flush) |=> err_flags[0]);

    assert_tx_over_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[0] && !err_clear[0]) |=> err_flags[0]);

    assert_rx_under_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[3] && !err_clear[3]) |=> err_flags[3]);

    assert_rx_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (part_q == 2'd1) |-> (rx_level == '0));

    assert_tx_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (part_q == 2'd2) |-> (tx_full && tx_empty));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0) && (rx_level == '0));

    assert_rx_rise_needs_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level > $past(rx_level)) |-> $past(seq_push));
endmodule

bind fifo_pair fifo_pair_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .part_q(part_q),
    .host_push(host_push), .seq_pull(seq_pull), .seq_push(seq_push),
    .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
    .err_flags(err_flags), .err_clear(err_clear)
);

// File: tb/fifo_pair_tb.sv
// Directed bench for fifo_pair: one task per scenario, each checking its results.
module fifo_pair_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  join_mode = 2'd0;
    logic        host_push = 1'b0, host_pop = 1'b0, seq_pull = 1'b0, seq_push = 1'b0;
    logic [31:0] host_wdata = '0, seq_push_data = '0;
    logic [31:0] host_rdata, seq_pull_data;
    logic [3:0]  tx_level, rx_level, err_flags;
    logic [3:0]  err_clear = '0;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .join_mode(join_mode),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .host_rdata(host_rdata), .seq_pull(seq_pull), .seq_pull_data(seq_pull_data),
        .seq_push(seq_push), .seq_push_data(seq_push_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .err_flags(err_flags), .err_clear(err_clear)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock of stimulus, applied at a falling edge and released at the next.
    task automatic step(logic hp, logic [31:0] hw, logic hq, logic sp, logic [31:0] sw,
                        logic sq, logic [3:0] clr);
        host_push = hp; host_wdata = hw; host_pop = hq;
        seq_push = sp; seq_push_data = sw; seq_pull = sq; err_clear = clr;
        @(negedge clk);
        host_push = 0; host_pop = 0; seq_push = 0; seq_pull = 0; err_clear = '0;
    endtask

    task automatic t_reset;
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 empty/full", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk("R1 err", err_flags, 0);
        chk("R1 rdata", host_rdata | seq_pull_data, 0);
    endtask

    task automatic t_split_tx;
        for (int i = 0; i < 4; i++) step(1, 32'hA0 + i, 0, 0, 0, 0, 0);
        chk("R2 tx_level", tx_level, 4);
        chk("R2 tx_full", tx_full, 1);
        step(1, 32'hDEAD, 0, 0, 0, 0, 0);
        chk("R4 level kept", tx_level, 4);
        chk("R4 tx overrun", err_flags, 4'b0001);
        for (int i = 0; i < 4; i++) begin
            chk("R3 tx order", seq_pull_data, 32'hA0 + i);
            step(0, 0, 0, 0, 0, 1, 0);
        end
        chk("R3 empty reads 0", seq_pull_data, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R5 tx underrun", err_flags, 4'b0011);
        chk("R5 level 0", tx_level, 0);
    endtask

    task automatic t_clear;
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R6 sticky", err_flags, 4'b0011);
        step(0, 0, 0, 0, 0, 1, 4'b0010);
        chk("R6 set wins", err_flags, 4'b0011);
        step(0, 0, 0, 0, 0, 0, 4'b0011);
        chk("R6 cleared", err_flags, 4'b0000);
    endtask

    task automatic t_wrap_rx;
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 32'hB0 + i, 0, 0);
        for (int i = 0; i < 2; i++) begin
            chk("R3 rx order", host_rdata, 32'hB0 + i);
            step(0, 0, 1, 0, 0, 0, 0);
        end
        step(0, 0, 1, 1, 32'hB3, 0, 0);
        chk("R10 level same", rx_level, 1);
        chk("R10 head moved", host_rdata, 32'hB3);
        for (int i = 4; i < 7; i++) step(0, 0, 0, 1, 32'hB0 + i, 0, 0);
        chk("R2 rx_full", {rx_full, rx_level}, {1'b1, 4'd4});
        for (int i = 3; i < 7; i++) begin
            chk("R3 rx wrap order", host_rdata, 32'hB0 + i);
            step(0, 0, 1, 0, 0, 0, 0);
        end
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R5 rx underrun", err_flags, 4'b1000);
        step(0, 0, 0, 0, 0, 0, 4'b1000);
    endtask

    task automatic t_join_tx;
        step(0, 0, 0, 1, 32'hC0, 0, 0);
        step(1, 32'hC1, 0, 0, 0, 0, 0);
        join_mode = 2'd1;
        step(1, 32'hC2, 0, 0, 0, 0, 0);
        chk("R9 flush levels", {tx_level, rx_level}, 8'h00);
        chk("R9 errors kept", err_flags, 0);
        for (int i = 0; i < 8; i++) step(1, 32'hD0 + i, 0, 0, 0, 0, 0);
        chk("R7 tx 8 deep", {tx_full, tx_level}, {1'b1, 4'd8});
        chk("R7 rx zero cap", {rx_full, rx_empty}, 2'b11);
        step(0, 0, 0, 1, 32'hEE, 0, 0);
        chk("R7 rx overrun", err_flags, 4'b0100);
        for (int i = 0; i < 8; i++) begin
            chk("R7 tx order", seq_pull_data, 32'hD0 + i);
            step(0, 0, 0, 0, 0, 1, 0);
        end
        step(0, 0, 0, 0, 0, 0, 4'b0100);
    endtask

    task automatic t_join_rx;
        step(1, 32'hF0, 0, 0, 0, 0, 0);
        join_mode = 2'd2;
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R9 flush tx", tx_level, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 32'h50 + i, 0, 0);
        chk("R8 rx 8 deep", {rx_full, rx_level}, {1'b1, 4'd8});
        chk("R8 tx zero cap", {tx_full, tx_empty}, 2'b11);
        step(1, 32'h77, 0, 0, 0, 0, 0);
        chk("R8 tx overrun", err_flags, 4'b0001);
        for (int i = 0; i < 8; i++) begin
            chk("R8 rx order", host_rdata, 32'h50 + i);
            step(0, 0, 1, 0, 0, 0, 0);
        end
        join_mode = 2'd3;
        step(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 32'h60 + i, 0, 0, 0, 0, 0);
        chk("R2 mode 3 split", {tx_full, tx_level}, {1'b1, 4'd4});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split_tx();
        t_clear();
        t_wrap_rx();
        t_join_tx();
        t_join_rx();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule